// File: doc/BRIEF.md
# Polled SPI Master with Bus-Contention Fault

This block is a serial peripheral interface controller that runs as bus master under software control. Software writes a word into a single-entry transmit holding register; when the controller is enabled and in master mode it moves that word into its shift register, generates a burst of SCK pulses from a power-of-two divider, shifts the word out MSB first on MOSI and collects the same number of bits from MISO into a single-entry receive holding register. Clock polarity, clock phase and the frame length (4 to 16 bits) are programmable, so all four SPI modes can be used.

Three status flags drive a polling loop. The transmit-empty flag means a new word may be written. It returns as soon as the queued word enters the shifter, so the next word can be queued while the current one is on the wire. The receive-full flag means a complete frame has been received. The busy flag covers the time a frame is shifting.

The controller also guards against a second master on the bus. It derives an internal select level either from the select input pin or, under software management, from a control bit. If that level is low while the block is an enabled master, it demotes itself: master mode and enable drop, any frame in flight is abandoned and a sticky fault flag rises. An output-enable option instead drives the select line low itself and removes the select input from the fault check.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x1C00, the status register (address 1) reads 0x0002, SCK is low and the select output enable is low.
- R2: A frame is (L+1) bits long, where L is the length field in control bits 13:10; values below 3 count as 3. Bits leave MSB first. The received word is right-aligned in the data register (address 2) with zero upper bits.
- R3: SCK idles at the polarity bit (control bit 2). With phase bit (control bit 3) at 0 MISO is sampled on the first edge of each bit; with phase at 1 it is sampled on the second. All four combinations work.
- R4: The SCK period is 2^(B+1) system clocks, where B is the 3-bit rate field in control bits 6:4.
- R5: A data write sets the transmit buffer full (status bit 1, empty flag, reads 0). The buffer is moved into the shifter one cycle later when the block is an idle, enabled master. A data write while the buffer is full is ignored.
- R6: Status bit 0 sets when a frame's last SCK edge has passed and clears when the data register is read. A newer frame overwrites an unread word.
- R7: Status bit 2 (busy) is high from the cycle a word enters the shifter until its last SCK edge.
- R8: With enable (control bit 0) or master (control bit 1) low, no word is loaded and SCK does not toggle.
- R9: With software management (control bit 7) set, the select level comes from control bit 8 and the select pin is ignored; otherwise it comes from the select pin.
- R10: An internal select level of 0 while enabled, master and without output enable clears enable and master one cycle later, sets the fault flag (status bit 3), stops any frame and returns SCK to idle.
- R11: With output enable (control bit 9) set in an enabled master, the select output is driven low with its enable high, and the select level is not checked for a fault.
- R12: The fault flag stays set until a status read is followed by a control write. A control write without that read leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from bus_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| nss_in | input | 1 | Select pin level as seen by the block |
| nss_out | output | 1 | Select pin drive value |
| nss_oe | output | 1 | Select pin drive enable |

## Verification
If the shift or edge counter drifts, the error shows on the pins within one frame: the bits on MOSI or in the received word come out shifted or cut short, or SCK stays away from its idle level after busy drops. A stuck fault path shows one cycle after the select level falls, as enable and master remaining set in the control readback. A lost transmit or receive flag shows the first time software polls status after a write or after a frame. Random mode, length and rate frames, checked against a bus-level slave model, reach these states many times over.

// File: rtl/spim_ctrl.sv
module spim_ctrl #(
  parameter int DW   = 16,
  parameter int DIVW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  input  logic          nss_in,
  output logic          nss_out,
  output logic          nss_oe
);
  localparam int FW = $clog2(DW);
  localparam int EW = $clog2(2 * DW);
  localparam int CW = 10 + FW;

  logic          en_q, mst_q, cpol_q, cpha_q, swm_q, swl_q, soe_q;
  logic [2:0]    baud_q;
  logic [FW-1:0] fs_q;
  logic [DW-1:0] txb_q, rxb_q, tsh_q, rsh_q;
  logic          txf_q, rxf_q, busy_q, fault_q, arm_q, sckl_q;
  logic [DIVW-1:0] div_q;
  logic [EW-1:0] edge_q;

  logic wr_ctrl, rd_stat, wr_data, rd_data;
  assign wr_ctrl = bus_sel &  bus_wr & (bus_addr == 2'd0);
  assign rd_stat = bus_sel & ~bus_wr & (bus_addr == 2'd1);
  assign wr_data = bus_sel &  bus_wr & (bus_addr == 2'd2);
  assign rd_data = bus_sel & ~bus_wr & (bus_addr == 2'd2);

  logic unused_wd;
  assign unused_wd = ^bus_wdata[DW-1:CW];

  logic sel_lvl, run, fault_hit;
  assign sel_lvl   = swm_q ? swl_q : nss_in;
  assign run       = en_q & mst_q;
  assign fault_hit = run & ~soe_q & ~sel_lvl;

  logic [FW-1:0]   fs_eff;
  logic [EW-1:0]   last_edge;
  logic [DIVW-1:0] half_m1;
  assign fs_eff    = (fs_q < FW'(3)) ? FW'(3) : fs_q;
  assign last_edge = EW'({fs_eff, 1'b1});
  assign half_m1   = (DIVW'(1) << baud_q) - DIVW'(1);

  logic tick, lead, samp, shft, load, done;
  assign tick = busy_q & (div_q == half_m1);
  assign lead = ~edge_q[0];
  assign samp = tick &  (lead ^ cpha_q);
  assign shft = tick & ~(lead ^ cpha_q) & ~(lead & (edge_q == '0));
  assign load = run & ~busy_q & txf_q & ~fault_hit;
  assign done = tick & (edge_q == last_edge);

  logic [DW-1:0] rsh_nx, rx_word;
  assign rsh_nx  = {rsh_q[DW-2:0], miso};
  assign rx_word = samp ? rsh_nx : rsh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mst_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0;
      swm_q <= 1'b0; swl_q <= 1'b0; soe_q <= 1'b0;
      baud_q <= '0; fs_q <= FW'(7);
    end else begin
      if (wr_ctrl) begin
        en_q   <= bus_wdata[0];
        mst_q  <= bus_wdata[1];
        cpol_q <= bus_wdata[2];
        cpha_q <= bus_wdata[3];
        baud_q <= bus_wdata[6:4];
        swm_q  <= bus_wdata[7];
        swl_q  <= bus_wdata[8];
        soe_q  <= bus_wdata[9];
        fs_q   <= bus_wdata[10 +: FW];
      end
      if (fault_hit) begin
        en_q  <= 1'b0;
        mst_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      arm_q   <= 1'b0;
    end else if (fault_hit) begin
      fault_q <= 1'b1;
      arm_q   <= 1'b0;
    end else if (wr_ctrl) begin
      if (arm_q) fault_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (rd_stat && fault_q) begin
      arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txb_q <= '0;
      txf_q <= 1'b0;
    end else if (load) begin
      txf_q <= 1'b0;
    end else if (wr_data && !txf_q) begin
      txb_q <= bus_wdata;
      txf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sckl_q <= 1'b0; div_q <= '0; edge_q <= '0;
      tsh_q  <= '0;   rsh_q  <= '0;
    end else if (fault_hit || !run) begin
      busy_q <= 1'b0;
      sckl_q <= 1'b0;
    end else if (load) begin
      busy_q <= 1'b1;
      sckl_q <= 1'b0;
      div_q  <= '0;
      edge_q <= '0;
      tsh_q  <= txb_q << (FW'(DW - 1) - fs_eff);
      rsh_q  <= '0;
    end else if (tick) begin
      div_q  <= '0;
      sckl_q <= ~sckl_q;
      edge_q <= edge_q + 1'b1;
      if (samp) rsh_q <= rsh_nx;
      if (shft) tsh_q <= {tsh_q[DW-2:0], 1'b0};
      if (done) busy_q <= 1'b0;
    end else if (busy_q) begin
      div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxb_q <= '0;
      rxf_q <= 1'b0;
    end else if (done && run && !fault_hit) begin
      rxb_q <= rx_word;
      rxf_q <= 1'b1;
    end else if (rd_data) begin
      rxf_q <= 1'b0;
    end
  end

  assign sck     = cpol_q ^ sckl_q;
  assign mosi    = tsh_q[DW-1];
  assign nss_oe  = soe_q & run;
  assign nss_out = ~nss_oe;

  logic [CW-1:0] ctrl_rd;
  assign ctrl_rd = {fs_q, soe_q, swl_q, swm_q, baud_q, cpha_q, cpol_q, mst_q, en_q};

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = DW'(ctrl_rd);
      2'd1:    bus_rdata = DW'({fault_q, busy_q, ~txf_q, rxf_q});
      2'd2:    bus_rdata = rxb_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cpol,
  input logic en,
  input logic mst,
  input logic busy,
  input logic txf,
  input logic rxf,
  input logic fault,
  input logic nss_oe
);
  p_fault_demotes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (!en && !mst && !busy));

  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));

  p_load_frees_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txf);

  p_rx_after_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !fault && en && mst) |-> rxf);

  p_idle_unless_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && mst) |-> !busy);

  p_oe_blocks_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
    nss_oe |=> !$rose(fault));
endmodule

bind spim_ctrl spim_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cpol(cpol_q), .en(en_q), .mst(mst_q),
  .busy(busy_q), .txf(txf_q), .rxf(rxf_q), .fault(fault_q), .nss_oe(nss_oe)
);

// File: tb/spim_ctrl_bench.sv
module spim_ctrl_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sck, mosi, miso, nss_out, nss_oe;
  logic        nss_in = 1'b1;

  spim_ctrl u_spim_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .nss_in(nss_in),
    .nss_out(nss_out), .nss_oe(nss_oe)
  );

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc++;

  int ecount = 0, k = 0, frames = 0, w_b = 8, rise_a = 0, rise_b = 0;
  bit cpol_b = 0, cpha_b = 0, quiet = 1, prev_sck = 0, lead = 0;
  logic [15:0] got = '0;
  logic [15:0] sw_arr [64];
  logic [15:0] got_arr [64];

  always @(negedge clk) begin
    if (quiet) begin
      prev_sck = sck; ecount = 0; k = 0; got = '0;
    end else if (sck !== prev_sck) begin
      prev_sck = sck;
      lead = (sck != cpol_b);
      if (sck) begin rise_a = rise_b; rise_b = cyc; end
      if (lead ^ cpha_b) got = {got[14:0], mosi};
      else if (!(lead && ecount == 0)) k++;
      ecount++;
      if (ecount == 2 * w_b) begin
        got_arr[frames % 64] = got;
        frames++;
        ecount = 0; k = 0; got = '0;
      end
    end
  end

  assign miso = (k < w_b) ? sw_arr[frames % 64][w_b-1-k] : 1'b0;

  function automatic int flen(int fs);
    return ((fs < 3) ? 3 : fs) + 1;
  endfunction

  function automatic logic [15:0] msk(int fs);
    return 16'((32'd1 << flen(fs)) - 1);
  endfunction

  function automatic logic [15:0] mk(bit en, bit mst, bit cpol, bit cpha, int baud,
                                     bit swm, bit swl, bit soe, int fs);
    return 16'({fs[3:0], soe, swl, swm, baud[2:0], cpha, cpol, mst, en});
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cfg(logic [15:0] w);
    quiet = 1;
    cpol_b = w[2]; cpha_b = w[3]; w_b = flen(int'(w[13:10]));
    wr(2'd0, w);
    @(negedge clk);
    quiet = 0;
  endtask

  task automatic wait_done();
    logic [15:0] s;
    int n = 0;
    do begin
      @(negedge clk);
      peek(2'd1, s);
      n++;
    end while ((s[2] || !s[1]) && n < 20000);
  endtask

  task automatic frame(string req, logic [15:0] tx, int fs);
    logic [15:0] d;
    int fi = frames;
    wr(2'd2, tx);
    wait_done();
    @(negedge clk);
    chk({req, " tx bits"}, got_arr[fi % 64], tx & msk(fs));
    rd(2'd2, d);
    chk({req, " rx word"}, d, sw_arr[fi % 64] & msk(fs));
    chk({req, " idle level"}, sck, cpol_b);
  endtask

  initial begin
    logic [15:0] s, d;
    int seed, f0;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 64; i++) sw_arr[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    peek(2'd0, s); chk("R1 ctrl", s, 16'h1C00);
    peek(2'd1, s); chk("R1 status", s, 16'h0002);
    chk("R1 sck", sck, 0);
    chk("R1 oe", nss_oe, 0);

    cfg(mk(0, 1, 0, 0, 0, 1, 1, 0, 7));
    f0 = frames;
    wr(2'd2, 16'h00A5);
    repeat (30) @(negedge clk);
    peek(2'd1, s); chk("R8 held", s, 16'h0000);
    chk("R8 no edges", frames * 100 + ecount, f0 * 100);
    chk("R8 sck", sck, 0);
    cfg(mk(1, 1, 0, 0, 0, 1, 1, 0, 7));
    wait_done();
    @(negedge clk);
    chk("R2 msb first", got_arr[f0 % 64], 16'h00A5);
    rd(2'd2, d); chk("R2 rx", d, sw_arr[f0 % 64] & 16'h00FF);

    cfg(mk(1, 1, 0, 0, 1, 1, 1, 0, 7));
    f0 = frames;
    wr(2'd2, 16'h0033);
    peek(2'd1, s); chk("R5 full after write", s[1], 0);
    @(negedge clk);
    peek(2'd1, s); chk("R5 empty after load", s[1], 1);
    chk("R7 busy", s[2], 1);
    wr(2'd2, 16'h00C4);
    wr(2'd2, 16'h0077);
    wait_done();
    repeat (4) @(negedge clk);
    chk("R5 frames", frames - f0, 2);
    chk("R5 first", got_arr[f0 % 64], 16'h0033);
    chk("R5 second", got_arr[(f0 + 1) % 64], 16'h00C4);
    peek(2'd1, s); chk("R6 rx full", s[0], 1);
    rd(2'd2, d); chk("R6 overwrite", d, sw_arr[(f0 + 1) % 64] & 16'h00FF);
    peek(2'd1, s); chk("R6 cleared", s[0], 0);

    cfg(mk(1, 1, 0, 0, 2, 1, 1, 0, 7));
    frame("R4 b2", 16'h005A, 7);
    chk("R4 period b2", rise_b - rise_a, 8);
    cfg(mk(1, 1, 0, 0, 7, 1, 1, 0, 3));
    frame("R4 b7", 16'h0009, 3);
    chk("R4 period b7", rise_b - rise_a, 256);

    for (int i = 0; i < 24; i++) begin
      bit cp = 1'($urandom), ch = 1'($urandom);
      int bd = int'($urandom % 3), fs = int'($urandom % 16);
      if (i < 4) begin cp = i[1]; ch = i[0]; end
      cfg(mk(1, 1, cp, ch, bd, 1, 1, 0, fs));
      frame($sformatf("R3 R2 mode%0d len%0d", {cp, ch}, fs), 16'($urandom), fs);
    end

    cfg(mk(1, 1, 0, 0, 0, 1, 0, 0, 7));
    repeat (2) @(negedge clk);
    peek(2'd1, s); chk("R10 sw fault", s[3], 1);
    peek(2'd0, s); chk("R10 demoted", s[1:0], 0);
    cfg(mk(1, 1, 0, 0, 0, 1, 1, 0, 7));
    peek(2'd1, s); chk("R12 sticky", s[3], 1);
    peek(2'd0, s); chk("R12 write taken", s[1:0], 3);
    rd(2'd1, s);
    cfg(mk(1, 1, 0, 0, 0, 1, 1, 0, 7));
    peek(2'd1, s); chk("R12 cleared", s[3], 0);

    nss_in = 1'b1;
    cfg(mk(1, 1, 0, 0, 0, 0, 0, 0, 7));
    repeat (3) @(negedge clk);
    peek(2'd1, s); chk("R9 pin high ok", s[3], 0);
    nss_in = 1'b0;
    repeat (2) @(negedge clk);
    peek(2'd1, s); chk("R10 pin fault", s[3], 1);
    rd(2'd1, s);
    cfg(mk(1, 1, 0, 0, 0, 1, 1, 0, 7));
    repeat (3) @(negedge clk);
    peek(2'd1, s); chk("R9 pin ignored", s[3], 0);
    peek(2'd0, s); chk("R9 still master", s[1:0], 3);
    frame("R9 frame", 16'h0096, 7);

    cfg(mk(1, 1, 0, 0, 0, 0, 0, 1, 7));
    repeat (3) @(negedge clk);
    peek(2'd1, s); chk("R11 no fault", s[3], 0);
    chk("R11 oe", nss_oe, 1);
    chk("R11 out", nss_out, 0);
    frame("R11 frame", 16'h00E1, 7);

    nss_in = 1'b1;
    cfg(mk(1, 1, 1, 0, 3, 0, 0, 0, 15));
    wr(2'd2, 16'hBEEF);
    repeat (40) @(negedge clk);
    peek(2'd1, s); chk("R7 mid frame busy", s[2], 1);
    nss_in = 1'b0;
    repeat (3) @(negedge clk);
    peek(2'd1, s); chk("R10 abort", s[3:2], 2'b10);
    chk("R10 sck idle", sck, 1);
    quiet = 1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule